// File: doc/BRIEF.md
# Serial mouse packet encoder

This block turns a single mouse event into a five-byte packet and stores the bytes in a small circular byte queue. A host drains the queue one byte at a time through a read port. An event has three parts: a signed horizontal motion value, a signed vertical motion value and three button states. The block is used where pointer events must be presented to software as a byte stream, with a flag that shows whether any byte is waiting.

The first byte of each packet is a header whose low three bits are active-low button flags. The second byte is the horizontal motion, clamped to the range of a symmetric signed byte. The third byte is the vertical motion, inverted in sign and then clamped in the same way. Two zero bytes close the packet.

Once an event is accepted, it is written into the queue one byte per cycle. While that happens, a busy output holds off further events. When the queue is full, any further byte is discarded without notice.

Top module: `mouse_pkt_enc`

## Requirements
- R1: While and directly after reset, `data_avail`, `evt_busy` and `rd_data` are all 0.
- R2: The first packet byte is 0x87 with bit 2 cleared if `evt_btn[2]` (left) is 1, bit 1 cleared if `evt_btn[1]` (middle) is 1, and bit 0 cleared if `evt_btn[0]` (right) is 1.
- R3: The second byte is `evt_dx` clamped to -127..+127, in two's complement (so 0x7F for large positive values and 0x81 for large negative ones).
- R4: The third byte is the negation of `evt_dy`, clamped to -127..+127, in two's complement.
- R5: The fourth and fifth bytes are 0x00. The bytes of one packet enter the queue in the order header, X, Y, zero, zero.
- R6: An event is accepted when `evt_valid` is 1 at a rising edge while `evt_busy` is 0. `evt_busy` is then 1 for exactly five cycles. A pulse on `evt_valid` while `evt_busy` is 1 is ignored and adds no bytes.
- R7: A read request (`rd_en` high at an edge) puts the oldest stored byte on `rd_data` after that same edge. Bytes leave the queue in the order they entered.
- R8: A read request on an empty queue returns 0x00 and leaves the queue unchanged.
- R9: A byte pushed while the queue holds `QUEUE_DEPTH` bytes is dropped. The stored bytes and their order are unaffected.
- R10: The write and read positions wrap from `QUEUE_DEPTH`-1 to 0, so first-in first-out order holds across the wrap.
- R11: `data_avail` is 1 whenever at least one byte is stored, including after a read that leaves bytes behind. It is 0 once the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe, one cycle |
| evt_dx | input | MOTION_W | Signed horizontal motion |
| evt_dy | input | MOTION_W | Signed vertical motion |
| evt_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| evt_busy | output | 1 | Packet being written, events ignored |
| rd_en | input | 1 | Read request for one byte |
| rd_data | output | 8 | Byte returned by the last read request |
| data_avail | output | 1 | At least one byte is stored |

## Verification
An event sampled at edge E0 raises `evt_busy` after E0. Its five bytes enter the queue at edges E1 to E5, and `evt_busy` falls after E5. The bench therefore counts busy cycles at falling edges and expects exactly five. A read request held across one rising edge yields its byte and the new `data_avail` after that edge. Each check samples at the following falling edge, one register stage after the request. The bench starts reads only after the busy window ends, so its reference queue, including drops when full, follows the same byte order the design sees.

// File: rtl/mpk_pkg.sv
`timescale 1ns/1ps
package mpk_pkg;
    localparam int          PKT_LEN  = 5;
    localparam int          SAT_LIM  = 127;
    localparam logic [7:0]  HDR_IDLE = 8'h87;

    typedef logic [7:0] byte_t;
    typedef logic [PKT_LEN-1:0][7:0] pkt_t;

    typedef struct packed {
        logic left;
        logic middle;
        logic right;
    } btn_t;

    function automatic byte_t sat_byte(input int v);
        if (v > SAT_LIM)       return byte_t'(SAT_LIM);
        else if (v < -SAT_LIM) return byte_t'(-SAT_LIM);
        else                   return v[7:0];
    endfunction

    function automatic byte_t hdr_byte(input btn_t b);
        return HDR_IDLE & ~{5'b0, b.left, b.middle, b.right};
    endfunction
endpackage

// File: rtl/mpk_packer.sv
`timescale 1ns/1ps
module mpk_packer
    import mpk_pkg::*;
#(
    parameter int MOTION_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       evt_valid,
    input  logic signed [MOTION_W-1:0] evt_dx,
    input  logic signed [MOTION_W-1:0] evt_dy,
    input  logic [2:0]                 evt_btn,
    output logic                       busy,
    output logic                       push,
    output byte_t                      push_data
);
    localparam int IW = $clog2(PKT_LEN);
    localparam logic [IW-1:0] LAST = IW'(PKT_LEN - 1);

    logic          busy_q;
    logic [IW-1:0] idx_q;
    pkt_t          pkt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            pkt_q  <= '0;
        end else if (!busy_q) begin
            if (evt_valid) begin
                pkt_q[0] <= hdr_byte(btn_t'(evt_btn));
                pkt_q[1] <= sat_byte(int'(evt_dx));
                pkt_q[2] <= sat_byte(-int'(evt_dy));
                pkt_q[3] <= 8'h00;
                pkt_q[4] <= 8'h00;
                busy_q   <= 1'b1;
                idx_q    <= '0;
            end
        end else if (idx_q == LAST) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign busy      = busy_q;
    assign push      = busy_q;
    assign push_data = pkt_q[idx_q];

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !busy) |=> busy);                               // R6
    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        (busy && idx_q == LAST) |=> !busy);                           // R6
    AST_HDR_FORM: assert property (@(posedge clk) disable iff (rst)
        (push && idx_q == '0) |-> push_data[7:3] == 5'b10000);        // R2
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (push && idx_q > IW'(2)) |-> push_data == 8'h00);             // R5
endmodule

// File: rtl/mpk_byte_queue.sv
`timescale 1ns/1ps
module mpk_byte_queue
    import mpk_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  byte_t push_data,
    input  logic  rd_en,
    output byte_t rd_data,
    output logic  avail
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    byte_t         mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q;
    byte_t         rd_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PTR_MAX) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (count_q != CNT_MAX);
    assign do_pop  = rd_en && (count_q != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            rd_q    <= '0;
        end else begin
            if (do_push) wptr_q <= ptr_inc(wptr_q);
            if (do_pop)  rptr_q <= ptr_inc(rptr_q);
            if (rd_en)   rd_q   <= do_pop ? mem[rptr_q] : 8'h00;
            count_q <= count_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign rd_data = rd_q;
    assign avail   = (count_q != '0);

    int span;
    always_comb begin
        if (wptr_q >= rptr_q) span = int'(wptr_q) - int'(rptr_q);
        else                  span = int'(wptr_q) + DEPTH - int'(rptr_q);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_MAX);                                          // R9
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_MAX && push && !rd_en) |=> count_q == CNT_MAX && $stable(wptr_q)); // R9
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && count_q == '0 && !push) |=> rd_data == 8'h00 && count_q == '0); // R8
    AST_PTR_SPAN: assert property (@(posedge clk) disable iff (rst)
        span == ((count_q == CNT_MAX) ? 0 : int'(count_q)));          // R10
    AST_AVAIL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && count_q > CW'(1)) |=> avail);                       // R11
endmodule

// File: rtl/mouse_pkt_enc.sv
`timescale 1ns/1ps
module mouse_pkt_enc
    import mpk_pkg::*;
#(
    parameter int MOTION_W    = 10,
    parameter int QUEUE_DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       evt_valid,
    input  logic signed [MOTION_W-1:0] evt_dx,
    input  logic signed [MOTION_W-1:0] evt_dy,
    input  logic [2:0]                 evt_btn,
    output logic                       evt_busy,
    input  logic                       rd_en,
    output logic [7:0]                 rd_data,
    output logic                       data_avail
);
    logic  push;
    byte_t push_data;

    mpk_packer #(.MOTION_W(MOTION_W)) u_packer (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_dx    (evt_dx),
        .evt_dy    (evt_dy),
        .evt_btn   (evt_btn),
        .busy      (evt_busy),
        .push      (push),
        .push_data (push_data)
    );

    mpk_byte_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .avail     (data_avail)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !evt_busy && !data_avail && rd_data == 8'h00);        // R1
endmodule

// File: tb/mouse_pkt_enc_bench.sv
`timescale 1ns/1ps
module mouse_pkt_enc_bench;
    localparam int MW    = 10;
    localparam int DEPTH = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 evt_valid = 1'b0;
    logic signed [MW-1:0] evt_dx = '0;
    logic signed [MW-1:0] evt_dy = '0;
    logic [2:0]           evt_btn = '0;
    logic                 evt_busy;
    logic                 rd_en = 1'b0;
    logic [7:0]           rd_data;
    logic                 data_avail;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [7:0] expq [$];

    always #2.5 clk = ~clk;

    mouse_pkt_enc #(.MOTION_W(MW), .QUEUE_DEPTH(DEPTH)) u_mouse_pkt_enc (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_dx(evt_dx),
        .evt_dy(evt_dy), .evt_btn(evt_btn), .evt_busy(evt_busy),
        .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sat(input int v);
        if (v > 127)  return 8'h7F;
        if (v < -127) return 8'h81;
        return v[7:0];
    endfunction

    task automatic model_push(input logic [7:0] b);
        if (expq.size() < DEPTH) expq.push_back(b);   // R9 drop when full
    endtask

    // Driver: sends an event, records expected bytes, optionally pulses an ignored event.
    task automatic send_evt(input int dx, input int dy, input logic [2:0] btn, input bit ign);
        int cnt;
        while (evt_busy) @(negedge clk);
        evt_dx = MW'(dx); evt_dy = MW'(dy); evt_btn = btn; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        model_push(8'h87 & ~{5'b0, btn});             // R2
        model_push(sat(dx));                          // R3
        model_push(sat(-dy));                         // R4
        model_push(8'h00);                            // R5
        model_push(8'h00);
        cnt = 0;
        while (evt_busy) begin
            if (ign && cnt == 0) begin
                evt_dx = 10'sd9; evt_dy = 10'sd9; evt_btn = 3'b111; evt_valid = 1'b1;
            end else begin
                evt_valid = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        evt_valid = 1'b0;
        chk(cnt == 5, "R6 busy length", cnt, 5);
    endtask

    // Monitor: issues a read and compares against the scoreboard head.
    task automatic read_chk(input string req);
        logic [7:0] exp;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        exp = (expq.size() != 0) ? expq.pop_front() : 8'h00;
        chk(rd_data == exp, req, rd_data, exp);
        chk(data_avail == (expq.size() != 0), "R11 data_avail", data_avail, expq.size() != 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!evt_busy && !data_avail && rd_data == 8'h00, "R1 reset state", {evt_busy, data_avail, rd_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!evt_busy && !data_avail && rd_data == 8'h00, "R1 after reset", {evt_busy, data_avail, rd_data}, 0);

        // Plain packet, no buttons, small motion
        send_evt(5, 3, 3'b000, 1'b0);
        chk(data_avail == 1'b1, "R11 avail after push", data_avail, 1);
        for (int i = 0; i < 5; i++) read_chk("R7 packet A order");
        read_chk("R8 empty read");
        read_chk("R8 empty read again");

        // Saturation and buttons; ignored pulse during busy; queue fills
        send_evt(300, -400, 3'b100, 1'b1);            // R6 ignored pulse
        send_evt(-512, 511, 3'b010, 1'b0);            // R3 R4 extremes
        send_evt(-127, 127, 3'b001, 1'b0);
        send_evt(127, -127, 3'b111, 1'b0);            // R9 four bytes dropped
        for (int i = 0; i < 16; i++) read_chk("R10 wrap order R9 drop");
        read_chk("R8 empty after drain");

        // Another packet across the wrapped pointers
        send_evt(-1, -1, 3'b101, 1'b0);
        for (int i = 0; i < 5; i++) read_chk("R2 R3 R4 R5 after wrap");
        read_chk("R8 final empty");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule